// File: doc/BRIEF.md
# Single-Set Tag Store with Age-Ordered Replacement

This block holds one set of an N-way associative tag store, of the kind placed in front of an address-translation table. Each way keeps a tag, a data word, a valid flag and a small age counter. A lookup presents a tag and gets back, in the same cycle, whether an active way matched, which way it was, and that way's data. A write presents a tag and a data word. It goes into the lowest-numbered empty way. When every way is occupied, it replaces the way that was touched longest ago.

Recency is tracked with one age counter per way. A way that has just been touched gets age zero. The active ways that were more recent than it move one step older. The oldest active way therefore always holds the largest age, and a chain of comparators finds it, taking the lowest index on a tie. The age update lands one cycle after the access that caused it. During that cycle the block holds its ready output low. A single invalidate input empties the whole set in one cycle.

Top module: `aset_store`

## Requirements
- R1: After a synchronous active-low reset, no way is active. Every lookup misses and `req_ready` is high.
- R2: A lookup reports `lkp_hit` in the cycle it is accepted, together with `lkp_way` and that way's data, and only an active way can match. If several active ways hold the same tag, the lowest-index one is reported.
- R3: A write accepted while at least one way is inactive stores into the lowest-index inactive way. `wr_way` shows that index in the write cycle.
- R4: A write accepted while all ways are active replaces the way touched (filled or hit) least recently. `wr_way` shows that index in the write cycle.
- R5: A hit makes the hit way the most recently touched way. The relative order of all other ways is kept.
- R6: Active ways always hold distinct ages once a pending age update has landed, and no age exceeds WAYS-1.
- R7: After an accepted write, or an accepted lookup that hits, `req_ready` is low for exactly the next cycle. Requests presented in that cycle are ignored. A lookup that misses does not stall.
- R8: When `wr_req` and `lkp_req` are both high in a ready cycle, only the write is performed and `lkp_hit` stays low.
- R9: `inval_all` deactivates every way and clears every age at the next edge, and cancels any pending age update. Requests in that cycle are ignored and `req_ready` reads low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inval_all | input | 1 | Empty the whole set at the next edge |
| wr_req | input | 1 | Write request |
| wr_tag | input | TAG_W | Tag to store |
| wr_data | input | DATA_W | Data word to store |
| lkp_req | input | 1 | Lookup request |
| lkp_tag | input | TAG_W | Tag to search for |
| req_ready | output | 1 | A request in this cycle is accepted |
| wr_way | output | clog2(WAYS) | Way the write in this cycle goes to |
| lkp_hit | output | 1 | Accepted lookup matched an active way |
| lkp_way | output | clog2(WAYS) | Matching way |
| lkp_data | output | DATA_W | Data of the matching way |

## Verification
A wrong age or valid bit does not show up at the moment it goes wrong. It shows up at the next write into a full set, when `wr_way` names a way other than the least recently touched one, or as a hit on a way that should be empty. The bench therefore keeps its own recency order of the ways and compares `wr_way`, `lkp_hit`, `lkp_way` and `lkp_data` against it on every cycle. It runs long random sequences with a small tag range, so that full-set evictions come often and a corrupted order is seen within a few writes. Repeated hits on one way and fills after an invalidate are exercised directly, because those are where merged ages and tie-breaks would become visible.

// File: rtl/aset_pkg.sv
// Package: shared helpers for the single-set tag store.
// Assumes: widths are derived from a way count of at least 1.
package aset_pkg;

    // Bits needed to index n items (at least one bit).
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Kind of request accepted in a cycle.
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_LOOKUP = 2'd1,
        OP_WRITE  = 2'd2
    } op_e;

endpackage

// File: rtl/aset_match.sv
// Module: tag comparator across all ways with lowest-index priority.
// Assumes: only ways whose active bit is set may match.
module aset_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [WAYS-1:0]            act,
    input  logic [TAG_W-1:0]           key,
    output logic                       hit,
    output logic [WAY_W-1:0]           way
);

    // Scan from the top so the lowest matching index wins.
    always_comb begin
        hit = 1'b0;
        way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (act[i] && (tags[i] == key)) begin
                hit = 1'b1;
                way = WAY_W'(i);
            end
        end
    end

endmodule

// File: rtl/aset_victim.sv
// Module: replacement choice - the lowest free way, else the oldest way.
// Assumes: the ages of active ways are meaningful; ties go to the lowest index.
module aset_victim #(
    parameter int WAYS  = 4,
    parameter int AGE_W = 2,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]            act,
    input  logic [WAYS-1:0][AGE_W-1:0] ages,
    output logic                       any_free,
    output logic [WAY_W-1:0]           victim
);

    logic [AGE_W-1:0] best_age [WAYS];
    logic [WAY_W-1:0] best_way [WAYS];
    logic [WAY_W-1:0] free_way;

    assign best_age[0] = ages[0];
    assign best_way[0] = '0;

    // Comparator chain: a strictly greater age replaces the running best.
    for (genvar g = 1; g < WAYS; g++) begin : g_max
        assign best_age[g] = (ages[g] > best_age[g-1]) ? ages[g] : best_age[g-1];
        assign best_way[g] = (ages[g] > best_age[g-1]) ? WAY_W'(g) : best_way[g-1];
    end

    // Lowest-index inactive way.
    always_comb begin
        free_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!act[i]) free_way = WAY_W'(i);
        end
    end

    assign any_free = ~&act;
    assign victim   = any_free ? free_way : best_way[WAYS-1];

endmodule

// File: rtl/aset_age.sv
// Module: per-way age counters with a deferred one-cycle update.
// Assumes: upd_prev is the touched way's age before the access (WAYS-1 for a fill).
module aset_age #(
    parameter int WAYS  = 4,
    parameter int AGE_W = 2,
    parameter int WAY_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       upd_en,
    input  logic [WAY_W-1:0]           upd_way,
    input  logic [AGE_W-1:0]           upd_prev,
    input  logic [WAYS-1:0]            act,
    output logic [WAYS-1:0][AGE_W-1:0] ages
);

    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

    // Touched way goes to zero; younger active ways step up and saturate.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ages <= '0;
        end else if (upd_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == upd_way) begin
                    ages[w] <= '0;
                end else if (act[w] && (ages[w] < upd_prev) && (ages[w] != AGE_MAX)) begin
                    ages[w] <= ages[w] + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/aset_store.sv
// Module: one set of an N-way tag store with age-ordered replacement.
// Assumes: one request per cycle; a write wins over a lookup; an age update
// follows each hit or fill one cycle later, and req_ready is low meanwhile.
module aset_store #(
    parameter int WAYS   = 4,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               inval_all,
    input  logic                               wr_req,
    input  logic [TAG_W-1:0]                   wr_tag,
    input  logic [DATA_W-1:0]                  wr_data,
    input  logic                               lkp_req,
    input  logic [TAG_W-1:0]                   lkp_tag,
    output logic                               req_ready,
    output logic [aset_pkg::idx_w(WAYS)-1:0]   wr_way,
    output logic                               lkp_hit,
    output logic [aset_pkg::idx_w(WAYS)-1:0]   lkp_way,
    output logic [DATA_W-1:0]                  lkp_data
);
    import aset_pkg::*;

    localparam int WAY_W = idx_w(WAYS);
    localparam int AGE_W = idx_w(WAYS);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

    logic [WAYS-1:0][TAG_W-1:0]  tag_q;
    logic [WAYS-1:0][DATA_W-1:0] data_q;
    logic [WAYS-1:0]             act_q;
    logic [WAYS-1:0][AGE_W-1:0]  age_q;
    logic                        busy_q;
    logic [WAY_W-1:0]            upd_way_q;
    logic [AGE_W-1:0]            upd_prev_q;

    logic             m_hit;
    logic [WAY_W-1:0] m_way;
    logic             any_free;
    logic [WAY_W-1:0] vict_way;
    op_e              op;

    aset_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .tags(tag_q), .act(act_q), .key(lkp_tag), .hit(m_hit), .way(m_way)
    );

    aset_victim #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)) u_victim (
        .act(act_q), .ages(age_q), .any_free(any_free), .victim(vict_way)
    );

    aset_age #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)) u_age (
        .clk(clk), .rst_n(rst_n), .clr(inval_all), .upd_en(busy_q),
        .upd_way(upd_way_q), .upd_prev(upd_prev_q), .act(act_q), .ages(age_q)
    );

    assign req_ready = !busy_q && !inval_all;

    // Decide which request, if any, is taken this cycle.
    always_comb begin
        if (!req_ready)   op = OP_IDLE;
        else if (wr_req)  op = OP_WRITE;
        else if (lkp_req) op = OP_LOOKUP;
        else              op = OP_IDLE;
    end

    assign wr_way   = vict_way;
    assign lkp_hit  = (op == OP_LOOKUP) && m_hit;
    assign lkp_way  = m_way;
    assign lkp_data = data_q[m_way];

    // Tag and data payload; not reset, only meaningful where active.
    always_ff @(posedge clk) begin
        if (op == OP_WRITE) begin
            tag_q[vict_way]  <= wr_tag;
            data_q[vict_way] <= wr_data;
        end
    end

    // Active bits: cleared by reset or invalidate, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n || inval_all) begin
            act_q <= '0;
        end else if (op == OP_WRITE) begin
            act_q[vict_way] <= 1'b1;
        end
    end

    // Pending age update recorded after a fill or a hit.
    always_ff @(posedge clk) begin
        if (!rst_n || inval_all) begin
            busy_q     <= 1'b0;
            upd_way_q  <= '0;
            upd_prev_q <= '0;
        end else begin
            busy_q <= (op == OP_WRITE) || ((op == OP_LOOKUP) && m_hit);
            if (op == OP_WRITE) begin
                upd_way_q  <= vict_way;
                upd_prev_q <= AGE_MAX;
            end else if (op == OP_LOOKUP && m_hit) begin
                upd_way_q  <= m_way;
                upd_prev_q <= age_q[m_way];
            end
        end
    end

endmodule

// File: rtl/aset_store_chk.sv
// Module: property checker for aset_store, attached with bind below.
// Assumes: act, ages and busy are the store's internal valid, age and pending flags.
module aset_store_chk #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2,
    parameter int AGE_W = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       inval_all,
    input logic                       wr_req,
    input logic                       lkp_req,
    input logic                       req_ready,
    input logic [WAY_W-1:0]           wr_way,
    input logic                       lkp_hit,
    input logic [WAY_W-1:0]           lkp_way,
    input logic [WAYS-1:0]            act,
    input logic [WAYS-1:0][AGE_W-1:0] ages,
    input logic                       busy
);

    logic dup_age;

    // Detect two active ways sharing an age.
    always_comb begin
        dup_age = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            for (int j = i + 1; j < WAYS; j++) begin
                if (act[i] && act[j] && ages[i] == ages[j]) dup_age = 1'b1;
            end
        end
    end

    // R1 R9
    empty_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |=> ($countones(act) == 0));

    // R2
    hit_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_hit |-> act[lkp_way]);

    // R4
    full_victim_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && req_ready && (&act)) |-> (ages[wr_way] == AGE_W'(WAYS - 1)));

    // R5
    hit_becomes_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_hit && !inval_all) |=> ##1 (ages[$past(lkp_way, 2)] == '0));

    // R6
    distinct_ages_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dup_age);

    // R7
    stall_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && req_ready && !inval_all) |=> !req_ready);

    // R7
    stall_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !inval_all) |=> (req_ready || inval_all));

    // R8
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && lkp_req) |-> !lkp_hit);

endmodule

bind aset_store aset_store_chk #(
    .WAYS(WAYS), .WAY_W(aset_pkg::idx_w(WAYS)), .AGE_W(aset_pkg::idx_w(WAYS))
) u_chk (
    .clk(clk), .rst_n(rst_n), .inval_all(inval_all), .wr_req(wr_req),
    .lkp_req(lkp_req), .req_ready(req_ready), .wr_way(wr_way),
    .lkp_hit(lkp_hit), .lkp_way(lkp_way), .act(act_q), .ages(age_q),
    .busy(busy_q)
);

// File: tb/aset_store_tb_top.sv
// Bench: behavioural recency-queue model compared with the store every cycle.
module aset_store_tb_top;
    localparam int WAYS   = 4;
    localparam int TAG_W  = 8;
    localparam int DATA_W = 16;
    localparam int WAY_W  = aset_pkg::idx_w(WAYS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              inval_all = 1'b0;
    logic              wr_req = 1'b0;
    logic [TAG_W-1:0]  wr_tag = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              lkp_req = 1'b0;
    logic [TAG_W-1:0]  lkp_tag = '0;
    logic              req_ready;
    logic [WAY_W-1:0]  wr_way;
    logic              lkp_hit;
    logic [WAY_W-1:0]  lkp_way;
    logic [DATA_W-1:0] lkp_data;

    aset_store #(.WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .inval_all(inval_all), .wr_req(wr_req),
        .wr_tag(wr_tag), .wr_data(wr_data), .lkp_req(lkp_req), .lkp_tag(lkp_tag),
        .req_ready(req_ready), .wr_way(wr_way), .lkp_hit(lkp_hit),
        .lkp_way(lkp_way), .lkp_data(lkp_data)
    );

    always #5 clk = ~clk;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    // Model: valid flags, payloads, and a queue of ways, most recent first.
    bit m_act [WAYS];
    int m_tag [WAYS];
    int m_dat [WAYS];
    int q[$];
    bit m_busy = 1'b0;

    task automatic chk(input string req, input int act_v, input int exp_v, input string what);
        n_chk++;
        if (act_v != exp_v) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act_v, exp_v, $time);
        end
    endtask

    function automatic int m_find(input int t);
        for (int i = 0; i < WAYS; i++) if (m_act[i] && m_tag[i] == t) return i;
        return -1;
    endfunction

    function automatic bit m_full();
        for (int i = 0; i < WAYS; i++) if (!m_act[i]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int m_victim();
        for (int i = 0; i < WAYS; i++) if (!m_act[i]) return i;
        return q[q.size() - 1];
    endfunction

    task automatic m_touch(input int w);
        for (int k = 0; k < q.size(); k++) if (q[k] == w) begin q.delete(k); break; end
        q.push_front(w);
    endtask

    task automatic m_clear();
        for (int i = 0; i < WAYS; i++) m_act[i] = 1'b0;
        q.delete();
        m_busy = 1'b0;
    endtask

    // One clock: drive, compare with the model, then advance the model.
    task automatic step(input bit inv, input bit wr, input int wt, input int wd,
                        input bit lk, input int lt, input string tg);
        bit exp_rdy, acc_wr, acc_lk, exp_hit;
        int hw, v;
        @(negedge clk);
        inval_all = inv; wr_req = wr; wr_tag = TAG_W'(wt); wr_data = DATA_W'(wd);
        lkp_req = lk; lkp_tag = TAG_W'(lt);
        #2;
        exp_rdy = !m_busy && !inv;
        chk("R7", int'(req_ready), int'(exp_rdy), "ready");
        acc_wr  = wr && exp_rdy;
        acc_lk  = lk && !wr && exp_rdy;
        hw      = m_find(lt);
        exp_hit = acc_lk && (hw >= 0);
        chk((wr && lk) ? "R8" : tg, int'(lkp_hit), int'(exp_hit), "hit");
        if (exp_hit) begin
            chk("R2", int'(lkp_way), hw, "hit way");
            chk("R2", int'(lkp_data), m_dat[hw], "hit data");
        end
        v = m_victim();
        if (acc_wr) chk(m_full() ? "R4" : "R3", int'(wr_way), v, "write way");
        @(posedge clk);
        if (inv) begin
            m_clear();
        end else begin
            if (acc_wr) begin
                m_act[v] = 1'b1; m_tag[v] = wt % 256; m_dat[v] = wd % 65536;
                m_touch(v);
            end else if (exp_hit) begin
                m_touch(hw);
            end
            m_busy = acc_wr || exp_hit;
        end
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 0, 0, 1'b0, 0, "R7");
    endtask

    task automatic wr(input int t, input int d, input string tg);
        step(1'b0, 1'b1, t, d, 1'b0, 0, tg);
        idle();
    endtask

    task automatic lk(input int t, input string tg);
        step(1'b0, 1'b0, 0, 0, 1'b1, t, tg);
        idle();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        m_clear();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: empty after reset
        lk(0, "R1");
        lk(8'h33, "R1");
        // R3: fill free ways in index order
        for (int i = 0; i < WAYS; i++) wr(16 + i, 100 + i, "R3");
        for (int i = 0; i < WAYS; i++) lk(16 + i, "R2");
        // R5: repeated hits on one way, then evictions follow recency
        for (int i = 0; i < 5; i++) lk(17, "R5");
        wr(40, 400, "R4");
        wr(41, 410, "R4");
        lk(17, "R5");
        wr(42, 420, "R4");
        wr(43, 430, "R4");
        lk(17, "R5");
        // R7: request during the stall is ignored, then a miss does not stall
        step(1'b0, 1'b1, 50, 500, 1'b0, 0, "R7");
        step(1'b0, 1'b1, 99, 990, 1'b0, 0, "R7");
        lk(99, "R7");
        step(1'b0, 1'b0, 0, 0, 1'b1, 98, "R7");
        step(1'b0, 1'b0, 0, 0, 1'b1, 50, "R7");
        idle();
        // R8: write wins over lookup
        step(1'b0, 1'b1, 60, 600, 1'b1, 50, "R8");
        idle();
        // R2: duplicate tag, lowest index reported
        wr(60, 601, "R4");
        lk(60, "R2");
        // R9: invalidate during a pending update, then ties after clearing
        step(1'b0, 1'b0, 0, 0, 1'b1, 60, "R2");
        step(1'b1, 1'b0, 0, 0, 1'b0, 0, "R9");
        lk(60, "R9");
        for (int i = 0; i < WAYS; i++) wr(70 + i, 700 + i, "R9");
        wr(80, 800, "R4");
        wr(81, 810, "R4");
        // Random mix over a small tag range
        for (int n = 0; n < 3000; n++) begin
            bit r_inv, r_wr, r_lk;
            r_inv = ($urandom_range(0, 79) == 0);
            r_wr  = ($urandom_range(0, 2) == 0);
            r_lk  = ($urandom_range(0, 1) == 0);
            step(r_inv, r_wr, $urandom_range(0, 7), $urandom_range(0, 65535),
                 r_lk, $urandom_range(0, 7), "R5");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule